// File: doc/BRIEF.md
# Key-Locked SDRAM Controller Configuration Registers

This block is the register bank that fronts the configuration space of an SDRAM controller. A 32-bit, word-access request port covers a 4 KB window, of which the lowest 64 words are implemented. The word at byte offset 0x000 is a protection key. Software must first write a fixed unlock word there. Until then, every write to any other word is silently dropped. Writing any other value to the key closes the bank again.

The word at byte offset 0x004 is the controller configuration. Some of its fields are read-only, and they keep their current value when software writes the word. Its reset contents, and which fields are read-only, depend on two elaboration parameters: a chip revision selector (0 or 1) and the installed RAM size in megabytes. The RAM size is encoded into a two-bit size code. All other words reset to zero and act as plain storage.

Reads return data one cycle after the request, with a response-valid strobe. Writes take effect at the clock edge that accepts them and produce no response.

Top module: `memcfg_regbank`

## Requirements
- R1: After reset, every implemented word reads zero except the configuration word. With revision 1 and a 1024 MB RAM size, the configuration word reads 0x1000000F: hardware version 1 in bits [31:28], aperture code 3 in bits [3:2], and size code 3 in bits [1:0].
- R2: With revision 0, the configuration word resets to bit 6 set plus a size code in bits [1:0]. The size code maps 64, 128, 256 and 512 MB to 0, 1, 2 and 3, and any other size falls back to code 2. A 100 MB setting therefore gives 0x00000042.
- R3: The key word at byte offset 0x000 accepts every write regardless of lock state, and reads back what was written.
- R4: While the key word differs from 0xFC600309, a write to any other word leaves that word unchanged.
- R5: While the key word equals 0xFC600309, writes to words 1 to 63 take effect.
- R6: Writing any value other than 0xFC600309 to the key word locks the bank again, so later writes to other words are dropped.
- R7: With revision 1, an unlocked write to the configuration word keeps the bits in mask 0xF00FC04C at their current value. The remaining bits take the written data.
- R8: With revision 0, the read-only mask of the configuration word is 0xFFFFF84C.
- R9: A read at a word index of 64 or more (byte address 0x100 and above) returns zero, and a write there changes no implemented word.
- R10: A read request raises the response-valid output exactly one cycle later, with the data. A write request, or no request, leaves response-valid low in the next cycle.
- R11: Address bits [1:0] are ignored, so byte address 0x015 reads word 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address in the 4 KB window |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read request |
| rspRdata | output | 32 | Read data |

## Verification
A write takes effect at the clock edge that accepts it, so a read issued in the very next cycle must already see the new value. Read data and response-valid are due exactly one cycle after the read request. The bench drives requests on falling edges and records the expected word for each read in a queue. A monitor on the following falling edge checks three things: that response-valid matches whether the previous cycle held a read, that the popped expected word matches the data, and that no response arrives without a matching queued read.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

  parameter int ADDR_W    = 12;
  parameter int DATA_W    = 32;
  parameter int NUM_WORDS = 64;
  parameter int IDX_W     = $clog2(NUM_WORDS);
  parameter int FULL_IDX_W = ADDR_W - 2;
  parameter int KEY_IDX   = 0;
  parameter int CFG_IDX   = 1;
  parameter logic [DATA_W-1:0] UNLOCK_WORD = 32'hFC60_0309;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             rdEn;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } ctrl_strb_t;

  function automatic logic [1:0] sizeCode(int rev, int ramMb);
    logic [1:0] code;
    if (rev == 0) begin
      case (ramMb)
        64:      code = 2'd0;
        128:     code = 2'd1;
        256:     code = 2'd2;
        512:     code = 2'd3;
        default: code = 2'd2;
      endcase
    end else begin
      case (ramMb)
        128:     code = 2'd0;
        256:     code = 2'd1;
        512:     code = 2'd2;
        1024:    code = 2'd3;
        default: code = 2'd2;
      endcase
    end
    return code;
  endfunction

  function automatic logic [DATA_W-1:0] cfgReset(int rev, int ramMb);
    logic [DATA_W-1:0] base;
    base = (rev == 0) ? 32'h0000_0040 : 32'h1000_000C;
    return base | {30'd0, sizeCode(rev, ramMb)};
  endfunction

  function automatic logic [DATA_W-1:0] roMask(int rev);
    return (rev == 0) ? 32'hFFFF_F84C : 32'hF00F_C04C;
  endfunction

endpackage

// File: rtl/memcfg_ctrl.sv
module memcfg_ctrl
  import memcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] keyWord,
  output ctrl_strb_t        strb,
  output logic              rspValid
);

  logic [FULL_IDX_W-1:0] fullIdx;
  logic                  inRange;
  logic                  unlocked;
  logic                  isKey;
  logic                  unusedLowBits;

  assign fullIdx       = reqAddr[ADDR_W-1:2];
  assign unusedLowBits = ^reqAddr[1:0];
  assign inRange       = (fullIdx < FULL_IDX_W'(NUM_WORDS));
  assign unlocked      = (keyWord == UNLOCK_WORD);
  assign isKey         = (fullIdx == FULL_IDX_W'(KEY_IDX));

  always_comb begin
    strb.wrEn  = reqValid && reqWrite && inRange && (isKey || unlocked);
    strb.wrIdx = fullIdx[IDX_W-1:0];
    strb.rdEn  = reqValid && !reqWrite;
    strb.rdHit = inRange;
    strb.rdIdx = fullIdx[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strb.rdEn;
  end

endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
  import memcfg_pkg::*;
#(
  parameter int REV    = 1,
  parameter int RAM_MB = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] keyWord,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] RO_MASK = roMask(REV);
  localparam logic [DATA_W-1:0] CFG_RST = cfgReset(REV, RAM_MB);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = (i == CFG_IDX) ? CFG_RST : '0;
    localparam bit HAS_RO = (i == CFG_IDX);
    logic hit;
    assign hit = strb.wrEn && (strb.wrIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        words[i] <= RST_VAL;
      end else if (hit) begin
        if (HAS_RO) words[i] <= (words[i] & RO_MASK) | (wdata & ~RO_MASK);
        else        words[i] <= wdata;
      end
    end
  end

  assign keyWord = words[KEY_IDX];
  assign cfgWord = words[CFG_IDX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      rdData <= strb.rdHit ? words[strb.rdIdx] : '0;
    end
  end

endmodule

// File: rtl/memcfg_regbank.sv
module memcfg_regbank
  import memcfg_pkg::*;
#(
  parameter int REV    = 1,
  parameter int RAM_MB = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  if (REV > 1 || REV < 0) begin : g_badRev
    $error("memcfg_regbank: unsupported revision selector");
  end

  ctrl_strb_t        strb;
  logic [DATA_W-1:0] keyWord;
  logic [DATA_W-1:0] cfgWord;

  memcfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .keyWord  (keyWord),
    .strb     (strb),
    .rspValid (rspValid)
  );

  memcfg_regs #(.REV(REV), .RAM_MB(RAM_MB)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (reqWdata),
    .keyWord (keyWord),
    .cfgWord (cfgWord),
    .rdData  (rspRdata)
  );

endmodule

// File: rtl/memcfg_regbank_chk.sv
module memcfg_regbank_chk
  import memcfg_pkg::*;
#(
  parameter int REV = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspRdata,
  input ctrl_strb_t        strb,
  input logic [DATA_W-1:0] keyWord,
  input logic [DATA_W-1:0] cfgWord
);

  localparam logic [DATA_W-1:0] RO_MASK = roMask(REV);

  // R10
  rd_rsp_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  // R9
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && (reqAddr[ADDR_W-1:2] >= FULL_IDX_W'(NUM_WORDS)))
      |=> (rspRdata == '0));

  // R4
  locked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrIdx != IDX_W'(KEY_IDX)) |-> (keyWord == UNLOCK_WORD));

  // R7
  cfg_ro_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrIdx == IDX_W'(CFG_IDX))
      |=> ((cfgWord & RO_MASK) == ($past(cfgWord) & RO_MASK)));

  // R4
  cfg_stable_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWord != UNLOCK_WORD) |=> $stable(cfgWord));

endmodule

bind memcfg_regbank memcfg_regbank_chk #(.REV(REV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspRdata (rspRdata),
  .strb     (strb),
  .keyWord  (keyWord),
  .cfgWord  (cfgWord)
);

// File: tb/memcfg_regbank_tb_top.sv
`timescale 1ns/1ps
module memcfg_regbank_tb_top;

  localparam logic [31:0] UNLOCK = 32'hFC60_0309;
  localparam logic [31:0] MASK_B = 32'hF00F_C04C;
  localparam logic [31:0] MASK_A = 32'hFFFF_F84C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 0, reqWrite = 0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;

  logic        aValid = 0, aWrite = 0;
  logic [11:0] aAddr = '0;
  logic [31:0] aWdata = '0;
  logic        aRspValid;
  logic [31:0] aRspRdata;

  memcfg_regbank #(.REV(1), .RAM_MB(1024)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata));

  memcfg_regbank #(.REV(0), .RAM_MB(100)) dutA_i (
    .clk(clk), .rstN(rstN), .reqValid(aValid), .reqWrite(aWrite),
    .reqAddr(aAddr), .reqWdata(aWdata), .rspValid(aRspValid), .rspRdata(aRspRdata));

  int tests = 0;
  int fails = 0;
  logic [31:0] mdl [64];

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: writes update the model by the requirement rules
  task automatic busWr(logic [11:0] addr, logic [31:0] data);
    int idx;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = addr; reqWdata = data;
    idx = int'(addr[11:2]);
    if (idx < 64) begin
      if (idx == 0) mdl[0] = data;
      else if (mdl[0] == UNLOCK) begin
        if (idx == 1) mdl[1] = (mdl[1] & MASK_B) | (data & ~MASK_B);
        else mdl[idx] = data;
      end
    end
  endtask

  task automatic busRd(logic [11:0] addr, string tag);
    int idx;
    item_t it;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = addr;
    idx = int'(addr[11:2]);
    it.exp = (idx < 64) ? mdl[idx] : 32'h0;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic busIdle();
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  // Monitor: response due one cycle after a read request
  logic prevRd = 0;
  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (rspValid !== prevRd) begin
        fails++;
        $display("FAIL R10 rspValid actual=%b expected=%b", rspValid, prevRd);
      end
      if (rspValid) begin
        if (sbq.size() == 0) begin
          tests++; fails++;
          $display("FAIL R10 response actual=1 expected=0 (no read pending)");
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(it.tag, rspRdata, it.exp);
        end
      end
    end
    prevRd = rstN && reqValid && !reqWrite;
  end

  task automatic aRd(logic [11:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    aValid = 1; aWrite = 0; aAddr = addr;
    @(negedge clk);
    aValid = 0;
    tests++;
    if (!aRspValid) begin
      fails++;
      $display("FAIL %s valid actual=0 expected=1", tag);
    end
    check(tag, aRspRdata, exp);
  endtask

  task automatic aWr(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    aValid = 1; aWrite = 1; aAddr = addr; aWdata = data;
    @(negedge clk);
    aValid = 0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
    mdl[1] = 32'h1000_000F;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset contents
    for (int i = 0; i < 64; i++) busRd(12'(i * 4), "R1 reset word");
    busIdle();

    // R2: revision 0 with fallback size
    aRd(12'h004, 32'h0000_0042, "R2 rev0 cfg reset");

    // R4: locked writes dropped
    busWr(12'h014, 32'h1234_5678);
    busWr(12'h004, 32'hFFFF_FFFF);
    busRd(12'h014, "R4 locked word5");
    busRd(12'h004, "R4 locked cfg");

    // R3: key always writable
    busWr(12'h000, UNLOCK);
    busRd(12'h000, "R3 key readback");

    // R5: unlocked writes land
    busWr(12'h014, 32'hA5A5_0001);
    busWr(12'h0FC, 32'h5A5A_0063);
    busRd(12'h014, "R5 word5");
    busRd(12'h0FC, "R5 word63");

    // R11: low address bits ignored
    busRd(12'h015, "R11 byte addr 0x015");
    busRd(12'h017, "R11 byte addr 0x017");

    // R7: read-only bits of cfg kept
    busWr(12'h004, 32'hFFFF_FFFF);
    busRd(12'h004, "R7 cfg all ones");
    busWr(12'h004, 32'h0000_0000);
    busRd(12'h004, "R7 cfg all zeros");

    // R9: out-of-range access
    busWr(12'h100, 32'hDEAD_BEEF);
    busRd(12'h100, "R9 oob read 0x100");
    busRd(12'hFFC, "R9 oob read 0xFFC");
    busRd(12'h000, "R9 key not aliased");
    busRd(12'h014, "R9 word5 intact");

    // R6: relock
    busWr(12'h000, 32'h0000_0001);
    busWr(12'h014, 32'h0000_0099);
    busRd(12'h014, "R6 relocked word5");
    busWr(12'h000, UNLOCK);
    busWr(12'h014, 32'h0000_0077);
    busRd(12'h014, "R6 reunlocked word5");
    busIdle();
    busIdle();

    // R8: revision 0 mask
    aWr(12'h000, UNLOCK);
    aWr(12'h004, 32'hFFFF_FFFF);
    aRd(12'h004, 32'h0000_07F3, "R8 rev0 cfg ones");
    aWr(12'h004, 32'h0000_0000);
    aRd(12'h004, 32'h0000_0040, "R8 rev0 cfg zeros");

    repeat (3) @(negedge clk);
    tests++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R10 pending reads actual=%0d expected=0", sbq.size());
    end
    finishRun();
  end

endmodule